// File: doc/BRIEF.md
# SM3 Message-Schedule Partial-Word Unit

This unit computes the first half of the SM3 message-expansion step over a 128-bit vector split into four 32-bit lanes. It takes three operands: the current destination value `d_i`, a first source `n_i` and a second source `m_i`. Lanes 0 to 2 combine `d_i XOR n_i` with a rotated word taken from the next-higher lane of `m_i`, and then pass through the linear permutation `x ^ rotl(x,15) ^ rotl(x,23)`. The top lane cannot be computed alongside them. It takes its rotated term from the already permuted lane 0 result, so one operation carries a serial chain from lane 0 into lane 3.

The unit has two register stages. Stage one forms lanes 0 to 2 and latches the XOR of the top lanes. Stage two finishes lane 3 and registers the full result. An issue strobe `valid_i` is answered exactly two cycles later. An enable input `ext_en_i` tells the unit whether the crypto extension is present. When it is low, the issue does not produce a result. Instead the unit raises `undef_o` at the same latency and leaves `result_o` unchanged. The unit uses only XOR and rotation, so it has no carries and produces no flags.

Top module: `sm3_pw1_unit`

## Requirements
- R1: For lanes 0, 1 and 2 (lane k in bits 32k+31:32k), the pre-value is `d XOR n` for that lane, XORed with `rotl(m lane k+1, 15)`.
- R2: Each lane's result is `p ^ rotl(p,15) ^ rotl(p,23)` applied to that lane's pre-value `p`, with 32-bit left rotations.
- R3: The lane 3 pre-value is `d XOR n` of lane 3, XORed with `rotl(final lane 0 result, 15)`.
- R4: An issue with `valid_i=1` and `ext_en_i=1` in cycle c gives a one-cycle `valid_o` pulse and its result on `result_o` in cycle c+2. Back-to-back issues are each answered.
- R5: An issue with `valid_i=1` and `ext_en_i=0` in cycle c gives a one-cycle `undef_o` pulse in cycle c+2 with `valid_o` low, and `result_o` keeps the last produced result.
- R6: `valid_o` and `undef_o` are never high in the same cycle.
- R7: All-zero operands give an all-zero result. A single set bit in any operand position gives the result that R1 to R3 predict.
- R8: Asserting `rst_ni` low drops `valid_o` and `undef_o` at once, and discards operations that are in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Issue strobe |
| ext_en_i | input | 1 | Crypto extension present |
| d_i | input | 128 | Current destination operand |
| n_i | input | 128 | First source operand |
| m_i | input | 128 | Second source operand |
| valid_o | output | 1 | Result valid, two cycles after issue |
| undef_o | output | 1 | Undefined-instruction flag, two cycles after a disabled issue |
| result_o | output | 128 | Result vector, held between valid results |

## Verification
A disabled issue and an enabled issue can be in the pipeline together. In one cycle, stage two can retire an undefined operation while stage one captures a real one, or the reverse. The bench provokes this by issuing every cycle with the enable drawn at random and in strict alternation. In every cycle it judges three things: both strobes against its two-deep expectation history, that the two strobes are never high together, and that `result_o` either equals the arithmetic model or still holds the last valid result.

// File: rtl/sm3_pw1_pkg.sv
package sm3_pw1_pkg;
  localparam int unsigned LANE_W = 32;
  localparam int unsigned LANES  = 4;
  localparam int unsigned ROT_M  = 15;
  localparam int unsigned ROT_P1 = 15;
  localparam int unsigned ROT_P2 = 23;

  typedef struct packed {
    logic vld;
    logic undef;
  } ctl_t;
endpackage

// File: rtl/sm3_pw1_perm.sv
module sm3_pw1_perm #(
  parameter int unsigned W     = 32,
  parameter int unsigned ROT_A = 15,
  parameter int unsigned ROT_B = 23
) (
  input  logic [W-1:0] x_i,
  output logic [W-1:0] y_o
);
  logic [W-1:0] rot_a, rot_b;

  assign rot_a = {x_i[W-1-ROT_A:0], x_i[W-1:W-ROT_A]};
  assign rot_b = {x_i[W-1-ROT_B:0], x_i[W-1:W-ROT_B]};
  assign y_o   = x_i ^ rot_a ^ rot_b;

  // R2: xor of three rotations of x keeps the parity of x
  always_comb begin
    a_r2_parity: assert (^y_o === ^x_i || $isunknown(x_i))
      else $error("perm parity mismatch");
  end
endmodule

// File: rtl/sm3_pw1_front.sv
module sm3_pw1_front
  import sm3_pw1_pkg::*;
#(
  parameter int unsigned W  = LANE_W,
  parameter int unsigned NL = LANES,
  parameter int unsigned RM = ROT_M
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic            ext_en_i,
  input  logic [NL*W-1:0] d_i,
  input  logic [NL*W-1:0] n_i,
  input  logic [NL*W-1:0] m_i,
  output ctl_t            ctl_q,
  output logic [(NL-1)*W-1:0] low_q,
  output logic [W-1:0]    top_q
);
  localparam int unsigned LOW_W = (NL-1)*W;

  logic [NL*W-1:0] dn;
  logic [LOW_W-1:0] low_d;

  assign dn = d_i ^ n_i;

  for (genvar k = 0; k < NL-1; k++) begin : g_lane
    logic [W-1:0] m_up, pre;
    assign m_up = m_i[(k+1)*W +: W];
    assign pre  = dn[k*W +: W] ^ {m_up[W-1-RM:0], m_up[W-1:W-RM]};
    sm3_pw1_perm #(.W(W), .ROT_A(ROT_P1), .ROT_B(ROT_P2)) u_perm (
      .x_i(pre),
      .y_o(low_d[k*W +: W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0;
    end else begin
      ctl_q.vld   <= valid_i & ext_en_i;
      ctl_q.undef <= valid_i & ~ext_en_i;
    end
  end

  // data captured only for enabled issues
  always_ff @(posedge clk_i) begin
    if (valid_i && ext_en_i) begin
      low_q <= low_d;
      top_q <= dn[(NL-1)*W +: W];
    end
  end

  a_r6_one_kind: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ctl_q.vld && ctl_q.undef))
    else $error("stage1 holds both kinds");
endmodule

// File: rtl/sm3_pw1_back.sv
module sm3_pw1_back
  import sm3_pw1_pkg::*;
#(
  parameter int unsigned W  = LANE_W,
  parameter int unsigned NL = LANES,
  parameter int unsigned RM = ROT_M
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  ctl_t                ctl_i,
  input  logic [(NL-1)*W-1:0] low_i,
  input  logic [W-1:0]        top_i,
  output logic                valid_o,
  output logic                undef_o,
  output logic [NL*W-1:0]     result_o
);
  logic [W-1:0] lane0, pre_top, fin_top;

  // serial dependency: top lane feeds on permuted lane 0
  assign lane0   = low_i[W-1:0];
  assign pre_top = top_i ^ {lane0[W-1-RM:0], lane0[W-1:W-RM]};

  sm3_pw1_perm #(.W(W), .ROT_A(ROT_P1), .ROT_B(ROT_P2)) u_perm_top (
    .x_i(pre_top),
    .y_o(fin_top)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      undef_o <= 1'b0;
    end else begin
      valid_o <= ctl_i.vld;
      undef_o <= ctl_i.undef;
    end
  end

  always_ff @(posedge clk_i) begin
    if (ctl_i.vld) result_o <= {fin_top, low_i};
  end

  // R5: a disabled op leaves the destination untouched
  a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    undef_o |-> $stable(result_o))
    else $error("result changed on undefined op");
endmodule

// File: rtl/sm3_pw1_unit.sv
module sm3_pw1_unit
  import sm3_pw1_pkg::*;
#(
  parameter int unsigned W  = LANE_W,
  parameter int unsigned NL = LANES
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic            ext_en_i,
  input  logic [NL*W-1:0] d_i,
  input  logic [NL*W-1:0] n_i,
  input  logic [NL*W-1:0] m_i,
  output logic            valid_o,
  output logic            undef_o,
  output logic [NL*W-1:0] result_o
);
  ctl_t                ctl_s1;
  logic [(NL-1)*W-1:0] low_s1;
  logic [W-1:0]        top_s1;

  sm3_pw1_front #(.W(W), .NL(NL), .RM(ROT_M)) u_front (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .ext_en_i(ext_en_i),
    .d_i     (d_i),
    .n_i     (n_i),
    .m_i     (m_i),
    .ctl_q   (ctl_s1),
    .low_q   (low_s1),
    .top_q   (top_s1)
  );

  sm3_pw1_back #(.W(W), .NL(NL), .RM(ROT_M)) u_back (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ctl_i   (ctl_s1),
    .low_i   (low_s1),
    .top_i   (top_s1),
    .valid_o (valid_o),
    .undef_o (undef_o),
    .result_o(result_o)
  );

  a_r4_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ext_en_i) |=> ##1 valid_o)
    else $error("valid_o missing two cycles after issue");

  a_r5_undef_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !ext_en_i) |=> ##1 (undef_o && !valid_o))
    else $error("undef_o missing two cycles after disabled issue");

  a_r6_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_o && undef_o))
    else $error("valid_o and undef_o together");

  a_r8_reset_quiet: assert property (@(posedge clk_i)
    !rst_ni |-> (!valid_o && !undef_o))
    else $error("strobe high during reset");
endmodule

// File: tb/sim_sm3_pw1_unit.sv
`timescale 1ns/1ps
module sim_sm3_pw1_unit;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic         ext_en_i = 1'b0;
  logic [127:0] d_i = '0, n_i = '0, m_i = '0;
  logic         valid_o, undef_o;
  logic [127:0] result_o;

  int unsigned n_chk = 0, n_fail = 0;
  bit done = 0;

  logic         exp_v [2];
  logic         exp_u [2];
  logic [127:0] exp_r [2];
  string        exp_t [2];
  logic [127:0] last_res;
  bit           res_known = 0;

  always #2.5 clk_i = ~clk_i;

  sm3_pw1_unit u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .ext_en_i(ext_en_i),
    .d_i(d_i), .n_i(n_i), .m_i(m_i),
    .valid_o(valid_o), .undef_o(undef_o), .result_o(result_o)
  );

  function automatic logic [31:0] rol(input logic [31:0] x, input int r);
    return (x << r) | (x >> (32 - r));
  endfunction

  function automatic logic [31:0] pmix(input logic [31:0] x);
    return x ^ rol(x, 15) ^ rol(x, 23);
  endfunction

  function automatic logic [127:0] model(input logic [127:0] d, n, m);
    logic [127:0] r;
    logic [127:0] x;
    x = d ^ n;
    for (int k = 0; k < 3; k++)
      r[32*k +: 32] = pmix(x[32*k +: 32] ^ rol(m[32*(k+1) +: 32], 15));
    r[127:96] = pmix(x[127:96] ^ rol(r[31:0], 15));
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic clear_hist();
    for (int i = 0; i < 2; i++) begin
      exp_v[i] = 0; exp_u[i] = 0; exp_r[i] = '0; exp_t[i] = "";
    end
  endtask

  // one cycle: judge outputs for the op issued two negedges ago, then drive
  task automatic cyc(input logic v, input logic e,
                     input logic [127:0] d, input logic [127:0] n,
                     input logic [127:0] m, input string tag);
    @(negedge clk_i);
    chk(valid_o === exp_v[1], "R4", "valid_o", 128'(valid_o), 128'(exp_v[1]));
    chk(undef_o === exp_u[1], "R5", "undef_o", 128'(undef_o), 128'(exp_u[1]));
    chk(!(valid_o && undef_o), "R6", "both strobes", 128'({valid_o, undef_o}), 128'(0));
    if (exp_v[1]) begin
      chk(result_o === exp_r[1], exp_t[1], "result_o", result_o, exp_r[1]);
      last_res  = exp_r[1];
      res_known = 1;
    end else if (exp_u[1] && res_known) begin
      chk(result_o === last_res, "R5", "held result_o", result_o, last_res);
    end
    exp_v[1] = exp_v[0]; exp_u[1] = exp_u[0];
    exp_r[1] = exp_r[0]; exp_t[1] = exp_t[0];
    exp_v[0] = v & e;
    exp_u[0] = v & ~e;
    exp_r[0] = model(d, n, m);
    exp_t[0] = tag;
    valid_i = v; ext_en_i = e; d_i = d; n_i = n; m_i = m;
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    #750000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    clear_hist();
    repeat (3) @(negedge clk_i);
    chk(valid_o === 1'b0, "R8", "valid_o in reset", 128'(valid_o), 128'(0));
    chk(undef_o === 1'b0, "R8", "undef_o in reset", 128'(undef_o), 128'(0));
    rst_ni = 1'b1;

    // R7 corners
    cyc(1, 1, '0, '0, '0, "R7 zeros");
    cyc(1, 1, '1, '0, '0, "R7 R1 ones d");
    cyc(1, 1, '0, '0, '1, "R7 R1 ones m");
    cyc(1, 1, '1, '1, '1, "R7 R2 ones all");
    // R7 single-bit sweeps over every position of each operand
    for (int b = 0; b < 128; b++) cyc(1, 1, 128'(1) << b, '0, '0, "R7 R1 R3 bit d");
    for (int b = 0; b < 128; b++) cyc(1, 1, '0, 128'(1) << b, '0, "R7 R1 R3 bit n");
    for (int b = 0; b < 128; b++) cyc(1, 1, '0, '0, 128'(1) << b, "R7 R1 R3 bit m");
    cyc(0, 0, '0, '0, '0, "");
    cyc(0, 0, '0, '0, '0, "");
    chk(result_o === model('0, '0, 128'(1) << 127), "R3", "last sweep held",
        result_o, model('0, '0, 128'(1) << 127));

    // R5 R6 strict alternation of disabled and enabled issues
    for (int i = 0; i < 64; i++)
      cyc(1, i[0], rnd128(), rnd128(), rnd128(), "R4 R1 R2 R3 alt");
    // R4 random data, random enable and gaps
    for (int i = 0; i < 3000; i++) begin
      logic v, e;
      v = ($urandom % 4) != 0;
      e = ($urandom % 3) != 0;
      cyc(v, e, rnd128(), rnd128(), rnd128(), "R4 R1 R2 R3 rand");
    end
    cyc(0, 0, '0, '0, '0, "");
    cyc(0, 0, '0, '0, '0, "");
    cyc(0, 0, '0, '0, '0, "");

    // R8: reset with work in flight
    cyc(1, 1, rnd128(), rnd128(), rnd128(), "R8");
    cyc(1, 0, '0, '0, '0, "R8");
    @(negedge clk_i);
    valid_i = 0;
    rst_ni  = 1'b0;
    #1;
    chk(valid_o === 1'b0, "R8", "valid_o at reset", 128'(valid_o), 128'(0));
    chk(undef_o === 1'b0, "R8", "undef_o at reset", 128'(undef_o), 128'(0));
    @(negedge clk_i);
    rst_ni = 1'b1;
    clear_hist();
    for (int i = 0; i < 4; i++) cyc(0, 0, '0, '0, '0, "");
    cyc(1, 1, rnd128(), rnd128(), rnd128(), "R4 after reset");
    for (int i = 0; i < 3; i++) cyc(0, 0, '0, '0, '0, "");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule